// File: doc/BRIEF.md
# Digital Input Interrupt Controller

This block watches a wide bank of digital input lines. Every line passes through a two-stage synchronizer clocked by the module clock. The host can read the synchronized levels of all lines at any time. A small subset of the lines, the low twelve, can request an interrupt. Each of these twelve has an enable bit and an edge-select bit. A qualifying transition on an enabled line sets a pending flag. The single request output to the host is the OR of the pending flags whose enable bits are set.

The host reaches the block through a simple register port. It presents a one-cycle request strobe with a write flag, a 3-bit address and 16 bits of write data. The block answers with a one-cycle acknowledge one clock later, carrying read data. Separately, an interrupt-acknowledge strobe returns a programmable 8-bit vector on the low data byte.

Requests are released by register access. Any access to the pending register, read or write, clears the flags it saw. An edge that lands in the same cycle stays pending and keeps the request asserted.

Top module: `irq_input_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0 and the enable (address 3), edge-select (address 4) and pending (address 5) registers read 0x0000.
- R2: Addresses 0, 1 and 2 return the synchronized input levels. Address 0 carries channels 15..0 on bits 15..0. Address 1 carries channels 31..16. Address 2 carries channels 39..32 on bits 7..0, with the upper byte 0.
- R3: On an enabled interrupt channel, edge-select bit 1 sets the pending flag on a 0-to-1 transition only. Edge-select bit 0 sets it on a 1-to-0 transition only. Register bit n maps to channel n, for n = 0..11.
- R4: A channel whose enable bit is 0 never sets its pending flag. Channels 12 and above never set any pending flag or request.
- R5: Consider an input change that is first sampled at clock edge k. The pending flag and `irq_o` are 0 after edge k+1 and are 1 after edge k+2. This gives 2 to 3 clock periods from the transition itself.
- R6: `irq_o` is the OR of pending flags whose enable bits are set. Clearing an enable bit drops that channel's request without losing its pending flag.
- R7: A register request strobe produces an acknowledge in exactly the next cycle, never otherwise. A write updates the addressed register. Read data is valid while the acknowledge is high.
- R8: An interrupt-acknowledge strobe produces an acknowledge in the next cycle, with the vector on bits 7..0 and 0 on bits 15..8.
- R9: A read or write of the pending register clears every flag set at that moment. A read returns those flags. A flag set by an edge in the same cycle remains pending.
- R10: The vector register (address 6, bits 7..0) resets to 0x00 and reads back what the host wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 40 | Raw digital input lines |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write flag for the access |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Write data |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| reg_rdata_o | output | 16 | Read data or vector, valid with acknowledge |
| reg_ack_o | output | 1 | Access complete, one cycle after the strobe |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
Some properties are checked on every cycle. The acknowledge timing and the vector returned on interrupt acknowledge are checked this way. So is the rule that a flag can only rise on an enabled channel, and that a pending access leaves no previously set flag standing unless a fresh edge set it again. The request output is also checked never to be high with all enables clear.

Other behaviour can only be shown by the bench scenarios. These cover the exact synchronizer latency, the edge selection for each polarity, and the packing of the 40 levels into data words. They also cover retention of a flag across disable and re-enable, and survival of an edge that coincides with the releasing read.

// File: rtl/irq_in_pkg.sv
package irq_in_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA0    = 3'd0,
    A_DATA1    = 3'd1,
    A_DATA2    = 3'd2,
    A_ENABLE   = 3'd3,
    A_EDGE_SEL = 3'd4,
    A_PENDING  = 3'd5,
    A_VECTOR   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int unsigned NUM_CH  = 40,
  parameter int unsigned NUM_IRQ = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CH-1:0]  din_i,
  output logic [NUM_CH-1:0]  sync_o,
  output logic [NUM_IRQ-1:0] prev_o
);
  logic [NUM_CH-1:0] meta_q, sync_q;
  logic [NUM_IRQ-1:0] prev_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= din_i[g];
        sync_q[g] <= meta_q[g];
      end
    end
    // only interrupt-capable channels need a delayed copy
    if (g < NUM_IRQ) begin : g_prev
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q[g] <= 1'b0;
        else         prev_q[g] <= sync_q[g];
      end
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int unsigned NUM_IRQ = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] cur_i,
  input  logic [NUM_IRQ-1:0] prev_i,
  input  logic [NUM_IRQ-1:0] enable_i,
  input  logic [NUM_IRQ-1:0] edge_sel_i,
  input  logic               release_i,
  output logic [NUM_IRQ-1:0] set_o,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] pending_q, rise, fall;

  assign rise  = cur_i & ~prev_i;
  assign fall  = ~cur_i & prev_i;
  assign set_o = enable_i & ((edge_sel_i & rise) | (~edge_sel_i & fall));

  // new edges win over a release in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= '0;
    else         pending_q <= (release_i ? '0 : pending_q) | set_o;
  end

  assign pending_o = pending_q;
  assign irq_o     = |(pending_q & enable_i);
endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
  import irq_in_pkg::*;
#(
  parameter int unsigned NUM_CH  = 40,
  parameter int unsigned NUM_IRQ = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               iack_i,
  input  logic [NUM_CH-1:0]  din_sync_i,
  input  logic [NUM_IRQ-1:0] pending_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               ack_o,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] edge_sel_o,
  output logic [7:0]         vector_o,
  output logic               release_o
);
  localparam int unsigned NW   = (NUM_CH + DATA_W - 1) / DATA_W;
  localparam int unsigned PADW = NW * DATA_W;

  logic [PADW-1:0]    din_pad;
  logic [NUM_IRQ-1:0] enable_q, edge_sel_q;
  logic [7:0]         vector_q;
  logic [DATA_W-1:0]  rdata_d, rdata_q;
  logic               ack_q;
  logic [DATA_W-1:0]  en_word, sel_word, pend_word;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    din_pad = '0;
    din_pad[NUM_CH-1:0] = din_sync_i;
    en_word = '0;
    en_word[NUM_IRQ-1:0] = enable_q;
    sel_word = '0;
    sel_word[NUM_IRQ-1:0] = edge_sel_q;
    pend_word = '0;
    pend_word[NUM_IRQ-1:0] = pending_i;
  end

  always_comb begin
    rdata_d = '0;
    if (iack_i) begin
      rdata_d = {8'h00, vector_q};
    end else if (32'(addr_i) < NW) begin
      rdata_d = din_pad[32'(addr_i)*DATA_W +: DATA_W];
    end else begin
      case (addr_i)
        A_ENABLE:   rdata_d = en_word;
        A_EDGE_SEL: rdata_d = sel_word;
        A_PENDING:  rdata_d = pend_word;
        A_VECTOR:   rdata_d = {8'h00, vector_q};
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q   <= '0;
      edge_sel_q <= '0;
      vector_q   <= '0;
      rdata_q    <= '0;
      ack_q      <= 1'b0;
    end else begin
      ack_q <= req_i | iack_i;
      if (req_i | iack_i) rdata_q <= rdata_d;
      if (req_i && we_i) begin
        case (addr_i)
          A_ENABLE:   enable_q   <= wdata_i[NUM_IRQ-1:0];
          A_EDGE_SEL: edge_sel_q <= wdata_i[NUM_IRQ-1:0];
          A_VECTOR:   vector_q   <= wdata_i[7:0];
          default:    ;
        endcase
      end
    end
  end

  assign release_o  = req_i && (addr_i == A_PENDING);
  assign rdata_o    = rdata_q;
  assign ack_o      = ack_q;
  assign enable_o   = enable_q;
  assign edge_sel_o = edge_sel_q;
  assign vector_o   = vector_q;
endmodule

// File: rtl/irq_input_ctrl.sv
module irq_input_ctrl
  import irq_in_pkg::*;
#(
  parameter int unsigned NUM_CH  = 40,
  parameter int unsigned NUM_IRQ = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] din_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              iack_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_ack_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0]  din_sync;
  logic [NUM_IRQ-1:0] din_prev, enable, edge_sel, pending, set;
  logic [7:0]         vector;
  logic               release_pend;

  irq_in_sync #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (din_i),
    .sync_o (din_sync),
    .prev_o (din_prev)
  );

  irq_edge_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_i      (din_sync[NUM_IRQ-1:0]),
    .prev_i     (din_prev),
    .enable_i   (enable),
    .edge_sel_i (edge_sel),
    .release_i  (release_pend),
    .set_o      (set),
    .pending_o  (pending),
    .irq_o      (irq_o)
  );

  irq_host_regs #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .iack_i     (iack_i),
    .din_sync_i (din_sync),
    .pending_i  (pending),
    .rdata_o    (reg_rdata_o),
    .ack_o      (reg_ack_o),
    .enable_o   (enable),
    .edge_sel_o (edge_sel),
    .vector_o   (vector),
    .release_o  (release_pend)
  );
endmodule

// File: rtl/irq_input_ctrl_chk.sv
module irq_input_ctrl_chk #(
  parameter int unsigned NUM_IRQ = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_req_i,
  input logic [2:0]         reg_addr_i,
  input logic               iack_i,
  input logic [15:0]        reg_rdata_o,
  input logic               reg_ack_o,
  input logic               irq_o,
  input logic [NUM_IRQ-1:0] enable,
  input logic [NUM_IRQ-1:0] pending,
  input logic [NUM_IRQ-1:0] set,
  input logic [7:0]         vector
);
  p_ack_one_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i || iack_i) |=> reg_ack_o);

  p_no_stray_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_req_i || iack_i) |=> !reg_ack_o);

  p_vector_on_iack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_i |=> (reg_rdata_o == {8'h00, $past(vector)}));

  p_release_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_addr_i == 3'd5) |=>
      ((pending & $past(pending) & ~$past(set)) == '0));

  p_pend_needs_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(enable)) == '0));

  p_irq_needs_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|enable));
endmodule

bind irq_input_ctrl irq_input_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_req_i   (reg_req_i),
  .reg_addr_i  (reg_addr_i),
  .iack_i      (iack_i),
  .reg_rdata_o (reg_rdata_o),
  .reg_ack_o   (reg_ack_o),
  .irq_o       (irq_o),
  .enable      (enable),
  .pending     (pending),
  .set         (set),
  .vector      (vector)
);

// File: tb/irq_input_ctrl_tb_top.sv
module irq_input_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:0] din = '0;
  logic        req = 1'b0, we = 1'b0, iack = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ack, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          chk;
    logic [15:0] exp;
    string       rq;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  irq_input_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .din_i       (din),
    .reg_req_i   (req),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .iack_i      (iack),
    .reg_rdata_o (rdata),
    .reg_ack_o   (ack),
    .irq_o       (irq)
  );

  task automatic check(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes the expected completion, then strobes for one cycle
  task automatic access(input bit w, input logic [2:0] a, input logic [15:0] wd,
                        input bit chk, input logic [15:0] exp, input string rq);
    exp_t e;
    e.chk = chk; e.exp = exp; e.rq = rq;
    sb_q.push_back(e);
    req = 1'b1; we = w; addr = a; wdata = wd;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string rq);
    access(1'b0, a, 16'h0, 1'b1, exp, rq);
    step(1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] wd);
    access(1'b1, a, wd, 1'b0, 16'h0, "R7");
    step(1);
  endtask

  task automatic do_iack(input logic [15:0] exp);
    exp_t e;
    e.chk = 1'b1; e.exp = exp; e.rq = "R8";
    sb_q.push_back(e);
    iack = 1'b1;
    @(negedge clk);
    iack = 1'b0;
    step(1);
  endtask

  task automatic chk_irq(input bit exp, input string rq);
    check(irq === exp, rq, {15'h0, irq}, {15'h0, exp});
  endtask

  // monitor: every acknowledge must match the oldest outstanding access
  always @(negedge clk) begin
    if (rst_ni && ack === 1'b1) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 stray ack", rdata, 16'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.chk) check(rdata === e.exp, e.rq, rdata, e.exp);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      check(1'b0, "watchdog", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);

    // R1, R10 reset state
    chk_irq(1'b0, "R1");
    rd(3'd3, 16'h0000, "R1 enable");
    rd(3'd4, 16'h0000, "R1 edge_sel");
    rd(3'd5, 16'h0000, "R1 pending");
    rd(3'd6, 16'h0000, "R10 vector reset");

    // R2 packing of levels
    din = 40'hA5_1234_C3F0;
    step(3);
    rd(3'd0, 16'hC3F0, "R2 word0");
    rd(3'd1, 16'h1234, "R2 word1");
    rd(3'd2, 16'h00A5, "R2 word2");
    din = 40'h5A_EDCB_0F3C;
    step(3);
    rd(3'd0, 16'h0F3C, "R2 word0 b");
    rd(3'd2, 16'h005A, "R2 word2 b");
    rd(3'd5, 16'h0000, "R4 no pend while disabled");
    chk_irq(1'b0, "R4");
    din = '0;
    step(4);

    // R10, R8 vector
    wr(3'd6, 16'hFFA5);
    rd(3'd6, 16'h00A5, "R10 vector readback");
    do_iack(16'h00A5);

    // R3, R5 rising edge on ch3
    wr(3'd4, 16'h0008);
    wr(3'd3, 16'h0008);
    rd(3'd3, 16'h0008, "R7 enable write");
    din[3] = 1'b1;
    step(2);
    chk_irq(1'b0, "R5 not before");
    step(1);
    chk_irq(1'b1, "R5 asserted");
    // R6 disable keeps flag, drops request
    wr(3'd3, 16'h0000);
    chk_irq(1'b0, "R6 disabled");
    wr(3'd3, 16'h0008);
    chk_irq(1'b1, "R6 re-enabled");
    rd(3'd5, 16'h0008, "R9 read returns flags");
    chk_irq(1'b0, "R9 released");
    rd(3'd5, 16'h0000, "R9 cleared");
    din[3] = 1'b0;
    step(4);
    chk_irq(1'b0, "R3 falling ignored when rising selected");

    // R3 falling on ch5
    wr(3'd4, 16'h0000);
    wr(3'd3, 16'h0020);
    din[5] = 1'b1;
    step(5);
    chk_irq(1'b0, "R3 rise ignored when falling selected");
    din[5] = 1'b0;
    step(2);
    chk_irq(1'b0, "R5 falling not before");
    step(1);
    chk_irq(1'b1, "R3 falling sets");
    rd(3'd5, 16'h0020, "R3 pending ch5");

    // R4 disabled and non-interrupt channels
    din[7]  = 1'b1;
    din[20] = 1'b1;
    din[39] = 1'b1;
    step(5);
    din[7]  = 1'b0;
    din[20] = 1'b0;
    step(5);
    chk_irq(1'b0, "R4 no irq");
    rd(3'd5, 16'h0000, "R4 no pending");
    din[39] = 1'b0;

    // R9 edge coinciding with releasing read
    wr(3'd4, 16'h0006);
    wr(3'd3, 16'h0006);
    din[1] = 1'b1;
    step(3);
    chk_irq(1'b1, "R3 ch1");
    din[2] = 1'b1;
    step(2);
    rd(3'd5, 16'h0002, "R9 snapshot");
    chk_irq(1'b1, "R9 late edge keeps irq");
    rd(3'd5, 16'h0004, "R9 late edge pending");
    chk_irq(1'b0, "R9 all released");

    // R9 write to pending also releases
    din[1] = 1'b0;
    step(4);
    din[1] = 1'b1;
    step(3);
    chk_irq(1'b1, "R9 before write");
    wr(3'd5, 16'h0000);
    chk_irq(1'b0, "R9 write release");
    rd(3'd5, 16'h0000, "R9 write cleared");

    step(3);
    check(sb_q.size() == 0, "R7 missing ack", 16'(sb_q.size()), 16'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule